// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets a clocked system read and write an external asynchronous static RAM of 128K 16-bit words that has a separate enable for each byte lane. A requester presents one transaction at a time on a valid/ready port. The transaction carries an address, a write flag, write data and a two-bit lane mask. The block then runs the memory's active-low chip, write, output and lane enables, drives the address, and controls a split tri-state data bus. All of these outputs come from registers. Each interval is a whole number of clock cycles set by a parameter: address setup, write pulse, data hold, read access and bus turnaround.

Writes hold output enable high for their whole length, so the shorter write pulse applies. Write enable rises first, while chip enable and the lane enables are still low. The data drivers are switched on only for the write pulse and the hold cycles that follow it. A read samples the bus at the end of the last access cycle. The captured word is returned with a one-cycle valid strobe. After the read, the block releases the memory for the turnaround interval and then spends at least one idle cycle in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, chip, write, output and both lane enables are high, the data drivers are off, `rd_valid` is low and `req_ready` is high.
- R2: `req_ready` is high only in the idle state. A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. A request offered while `req_ready` is low has no effect on the memory.
- R3: A write holds chip enable low for T_AS + T_WP + T_DH cycles. Write enable is high for the first T_AS cycles, low for the next T_WP cycles and high for the last T_DH cycles.
- R4: Output enable stays high for the whole of a write, and write enable and output enable are never low together.
- R5: The data drivers are on only during the write pulse and hold cycles, and only for the lanes set in the mask (mask bit 0 is data bits 7:0, bit 1 is bits 15:8). During those cycles `mem_dq_o` equals the request's write data.
- R6: The address appears on the same edge on which chip enable falls and stays stable while chip enable is low.
- R7: A read holds chip enable and output enable low and write enable high for T_ACC cycles. Each lane enable is low exactly when its mask bit is set.
- R8: `rd_valid` pulses for one cycle right after the last access cycle. `rd_data` then holds the bus value sampled at that edge, with unselected lanes forced to zero.
- R9: After a read, every enable stays high for T_TA turnaround cycles before `req_ready` rises.
- R10: Between any two transactions there is at least one cycle with `req_ready` high and all enables high.
- R11: A write ends with write enable rising while chip enable is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = low byte |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 16 | Read data |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq_o | output | 16 | Data to memory |
| mem_dq_oe | output | 2 | Per-lane driver enable |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The assertions need nothing from the requester except that the request fields are stable in the cycle in which they are taken. They also need the memory stand-in to drive the bus only while output enable is low. The bench drives every input at the falling edge. It also holds a stray write request high across busy cycles and drops it before the idle cycle, so the only request offered while `req_ready` is high is one the bench means to issue. The bench's stand-in memory puts a fixed filler pattern on lanes that are not enabled, which makes leaks through lane masking show up in `rd_data`.

// File: rtl/sram_ctrl_pkg.sv
// Shared types for the asynchronous static RAM sequencer.
package sram_ctrl_pkg;
    // Phases of one memory transaction.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WSETUP = 3'd1,
        PH_WPULSE = 3'd2,
        PH_WHOLD  = 3'd3,
        PH_RACC   = 3'd4,
        PH_RTURN  = 3'd5
    } phase_t;
endpackage

// File: rtl/sram_ctrl_seq.sv
// Phase sequencer: walks through write and read phases, each phase
// lasting a parameterised number of cycles (every duration assumed >= 1).
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int T_AS  = 1,
    parameter int T_WP  = 1,
    parameter int T_DH  = 1,
    parameter int T_ACC = 1,
    parameter int T_TA  = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   start_wr,
    output phase_t phase,
    output phase_t phase_nxt,
    output logic   last
);
    localparam int MAXD_A = (T_AS > T_WP) ? T_AS : T_WP;
    localparam int MAXD_B = (T_DH > T_ACC) ? T_DH : T_ACC;
    localparam int MAXD_C = (MAXD_A > MAXD_B) ? MAXD_A : MAXD_B;
    localparam int MAXD   = (MAXD_C > T_TA) ? MAXD_C : T_TA;
    localparam int CNT_W  = (MAXD < 2) ? 1 : $clog2(MAXD);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    assign last = (cnt == '0);

    // Next-phase selection.
    always_comb begin
        phase_nxt = phase;
        case (phase)
            PH_IDLE:   if (start) phase_nxt = start_wr ? PH_WSETUP : PH_RACC;
            PH_WSETUP: if (last) phase_nxt = PH_WPULSE;
            PH_WPULSE: if (last) phase_nxt = PH_WHOLD;
            PH_WHOLD:  if (last) phase_nxt = PH_IDLE;
            PH_RACC:   if (last) phase_nxt = PH_RTURN;
            PH_RTURN:  if (last) phase_nxt = PH_IDLE;
            default:   phase_nxt = PH_IDLE;
        endcase
    end

    // Duration (minus one) of the phase about to be entered.
    always_comb begin
        case (phase_nxt)
            PH_WSETUP: load_val = CNT_W'(T_AS - 1);
            PH_WPULSE: load_val = CNT_W'(T_WP - 1);
            PH_WHOLD:  load_val = CNT_W'(T_DH - 1);
            PH_RACC:   load_val = CNT_W'(T_ACC - 1);
            PH_RTURN:  load_val = CNT_W'(T_TA - 1);
            default:   load_val = '0;
        endcase
    end

    // Phase register and per-phase down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= phase_nxt;
            if (phase_nxt != phase) cnt <= load_val;
            else if (cnt != '0)     cnt <= cnt - 1'b1;
        end
    end

    // R10
    turn_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RTURN || phase == PH_WHOLD) && last |=> phase == PH_IDLE);
endmodule

// File: rtl/sram_ctrl_pins.sv
// Pin stage: captures the request when it is taken and registers every
// memory control, address and data output from the next phase, so pins
// only change on clock edges. Assumes request fields are valid on accept.
module sram_ctrl_pins
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  phase_t            phase_nxt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [LANES-1:0]  mem_dq_oe
);
    logic [LANES-1:0] mask_q;
    logic [LANES-1:0] mask_sel;
    logic             busy_nxt;
    logic             drive_nxt;

    assign mask_sel  = accept ? req_mask : mask_q;
    assign busy_nxt  = (phase_nxt != PH_IDLE) && (phase_nxt != PH_RTURN);
    assign drive_nxt = (phase_nxt == PH_WPULSE) || (phase_nxt == PH_WHOLD);

    // Request capture into the address and data output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mask_q   <= req_mask;
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
        end
    end

    // Registered control pins derived from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_be_n  <= '1;
            mem_dq_oe <= '0;
        end else begin
            mem_ce_n  <= !busy_nxt;
            mem_we_n  <= (phase_nxt != PH_WPULSE);
            mem_oe_n  <= (phase_nxt != PH_RACC);
            mem_be_n  <= busy_nxt ? ~mask_sel : '1;
            mem_dq_oe <= drive_nxt ? mask_sel : '0;
        end
    end

    // R4
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));
    // R5
    drive_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe != '0) |-> mem_oe_n && !mem_ce_n);
    // R5
    pulse_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe == ~mem_be_n);
    // R6
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n && $past(!mem_ce_n) |-> $stable(mem_addr));
    // R11
    we_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_ce_n && mem_be_n == $past(mem_be_n));
    // R3
    we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);
endmodule

// File: rtl/sram_ctrl_rdcap.sv
// Read capture: samples the data bus at the end of the last access cycle,
// zeroes lanes that were not enabled and raises a one-cycle strobe.
module sram_ctrl_rdcap #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  be_n,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] masked;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Pass a lane only when its enable is active.
        assign masked[g*LANE_W +: LANE_W] = be_n[g] ? '0 : dq_i[g*LANE_W +: LANE_W];
    end

    // Data and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= masked;
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
// Top level: asynchronous static RAM sequencer with a valid/ready request
// port. Assumes every timing parameter is at least one cycle.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int LANES  = 2,
    parameter int T_AS   = 1,
    parameter int T_WP   = 1,
    parameter int T_DH   = 1,
    parameter int T_ACC  = 1,
    parameter int T_TA   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [LANES-1:0]  mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    phase_t phase;
    phase_t phase_nxt;
    logic   last;
    logic   accept;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    sram_ctrl_seq #(
        .T_AS(T_AS), .T_WP(T_WP), .T_DH(T_DH), .T_ACC(T_ACC), .T_TA(T_TA)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .start_wr(req_write),
        .phase(phase), .phase_nxt(phase_nxt), .last(last)
    );

    sram_ctrl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_pins (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .phase_nxt(phase_nxt),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe)
    );

    sram_ctrl_rdcap #(.DATA_W(DATA_W), .LANES(LANES)) i_rdcap (
        .clk(clk), .rst_n(rst_n), .capture(phase == PH_RACC && last),
        .be_n(mem_be_n), .dq_i(mem_dq_i), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);
    // R8
    rd_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!mem_oe_n) && mem_oe_n);
    // R8
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: tb/test_sram_async_ctrl.sv
// Bench: behavioural stand-in memory, a per-cycle expected-pin model and
// a reference word store. Inputs driven and outputs sampled at negedge.
module test_sram_async_ctrl;
    localparam int AS = 2, WP = 3, DH = 1, ACC = 2, TA = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n;
    logic [15:0] rd_data, mem_dq_o, mem_dq_i;
    logic [16:0] mem_addr;
    logic [1:0]  mem_be_n, mem_dq_oe;

    int total = 0, bad = 0;
    logic [15:0] chip_mem [256];
    logic [15:0] ref_mem  [256];

    always #5 clk = ~clk;

    sram_async_ctrl #(.T_AS(AS), .T_WP(WP), .T_DH(DH), .T_ACC(ACC), .T_TA(TA))
    i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Stand-in memory read path: filler on lanes not enabled.
    always_comb begin
        mem_dq_i = 16'hA5A5;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (!mem_be_n[0]) mem_dq_i[7:0]  = chip_mem[mem_addr[7:0]][7:0];
            if (!mem_be_n[1]) mem_dq_i[15:8] = chip_mem[mem_addr[7:0]][15:8];
        end
    end

    // Stand-in memory write path.
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_be_n[0] && mem_dq_oe[0]) chip_mem[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
            if (!mem_be_n[1] && mem_dq_oe[1]) chip_mem[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare control pins against the expected values for this cycle.
    task automatic pins(input string tag, input logic ce, we, oe, input logic [1:0] be,
                        input logic [1:0] dqoe, input logic rdy);
        check({tag, " ctl"}, {26'd0, ce, we, oe, rdy, 2'b00}, {26'd0, mem_ce_n, mem_we_n, mem_oe_n, req_ready, 2'b00});
        check({tag, " be"}, {30'd0, mem_be_n}, {30'd0, be});
        check({tag, " dqoe"}, {30'd0, mem_dq_oe}, {30'd0, dqoe});
    endtask

    // One transaction with per-cycle expectations; noise offers a stray write while busy.
    task automatic txn(input logic wr, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m, input logic noise);
        logic [15:0] exp_rd;
        @(negedge clk);
        check("R10 idle before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        if (noise) begin
            req_write = 1'b1; req_addr = a ^ 17'h00080; req_wdata = 16'hBAD0; req_mask = 2'b11;
        end else req_valid = 1'b0;
        if (wr) begin
            for (int i = 0; i < AS; i++) begin
                pins("R3 setup", 1'b1 ^ 1'b1, 1'b1, 1'b1, ~m, 2'b00, 1'b0);
                check("R6 addr", {15'd0, mem_addr}, {15'd0, a});
                @(negedge clk);
            end
            for (int i = 0; i < WP; i++) begin
                pins("R4 pulse", 1'b0, 1'b0, 1'b1, ~m, m, 1'b0);
                check("R5 data", {16'd0, mem_dq_o}, {16'd0, d});
                @(negedge clk);
            end
            for (int i = 0; i < DH; i++) begin
                pins("R11 hold", 1'b0, 1'b1, 1'b1, ~m, m, 1'b0);
                @(negedge clk);
            end
            if (m[0]) ref_mem[a[7:0]][7:0]  = d[7:0];
            if (m[1]) ref_mem[a[7:0]][15:8] = d[15:8];
        end else begin
            for (int i = 0; i < ACC; i++) begin
                pins("R7 access", 1'b0, 1'b1, 1'b0, ~m, 2'b00, 1'b0);
                check("R6 addr", {15'd0, mem_addr}, {15'd0, a});
                check("R8 no early valid", {31'd0, rd_valid}, 32'd0);
                @(negedge clk);
            end
            exp_rd = ref_mem[a[7:0]] & {{8{m[1]}}, {8{m[0]}}};
            for (int i = 0; i < TA; i++) begin
                pins("R9 turn", 1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 1'b0);
                check("R8 valid", {31'd0, rd_valid}, (i == 0) ? 32'd1 : 32'd0);
                if (i == 0) check("R8 data", {16'd0, rd_data}, {16'd0, exp_rd});
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        pins("R10 standby", 1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 1'b1);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            chip_mem[i] = 16'h0000;
            ref_mem[i]  = 16'h0000;
        end
        repeat (3) @(negedge clk);
        pins("R1 in reset", 1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 1'b1);
        check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        pins("R1 after reset", 1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 1'b1);

        txn(1'b1, 17'h00012, 16'h1234, 2'b11, 1'b0);
        txn(1'b0, 17'h00012, 16'h0000, 2'b11, 1'b0);
        txn(1'b1, 17'h1FFFF, 16'hCAFE, 2'b11, 1'b0);
        txn(1'b1, 17'h1FFFF, 16'h77EE, 2'b01, 1'b0);   // low lane only
        txn(1'b0, 17'h1FFFF, 16'h0000, 2'b11, 1'b0);
        txn(1'b1, 17'h00040, 16'h5566, 2'b11, 1'b0);
        txn(1'b1, 17'h00040, 16'h99AA, 2'b10, 1'b0);   // high lane only
        txn(1'b0, 17'h00040, 16'h0000, 2'b01, 1'b0);   // R8 upper lane zeroed
        txn(1'b0, 17'h00040, 16'h0000, 2'b10, 1'b0);   // R8 lower lane zeroed
        // R2: stray write to 0x000C0 offered while busy must not land.
        txn(1'b1, 17'h00040, 16'h0F0F, 2'b11, 1'b1);
        txn(1'b0, 17'h000C0, 16'h0000, 2'b11, 1'b1);
        txn(1'b0, 17'h000C0, 16'h0000, 2'b11, 1'b0);
        txn(1'b0, 17'h00040, 16'h0000, 2'b11, 1'b0);
        // R1: reset in the middle of a write returns pins to standby.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_mask = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        pins("R1 mid reset", 1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule